// File: doc/BRIEF.md
# Soft Mute Ramp with Zero-Run Detector

This block sits on the per-sample path of signed stereo audio and scales both channels by a shared gain. The gain is chosen by a step index into a table of multipliers spaced about 0.5 dB apart. While the mute input is high, every accepted sample pushes the index one step deeper, so the output fades toward silence instead of cutting off. Past the last table entry the output is forced to exactly zero. When mute drops, the index walks back to unity at the same rate of one step per sample.

The block also watches the incoming samples. It raises a flag once a long run of consecutive all-zero samples has been seen. In normal mode both channels must be zero. In bypass mode only the single stream carried on the left lane counts.

Samples enter on a valid/ready stream and leave on a second valid/ready stream through one register stage. An input sample is taken in a cycle where `s_valid` and `s_ready` are both high. After the start-up hold, `s_ready` is high whenever the output register is empty or is being drained that cycle (`!m_valid || m_ready`). While `m_ready` is low and `m_valid` is high, the output data holds still and no new sample is taken. The mute and bypass pins are plain level controls, sampled in the cycle a sample is accepted.

Top module: `mute_ramp_zdet`

## Requirements
- R1: After `rst_n` rises, the block holds for INIT_CYCLES (default 1024) clock cycles. In that time `s_ready` and `m_valid` stay low and `m_left`/`m_right` stay zero. `s_ready` first goes high in the cycle after the INIT_CYCLES-th rising edge following release.
- R2: A sample accepted at a clock edge appears on `m_left`/`m_right` with `m_valid` high right after that edge. While `m_valid` is high and `m_ready` is low, `m_valid`, `m_left` and `m_right` hold and `s_ready` is low.
- R3: With the step index at 0 (unity), each output equals its input sample bit for bit.
- R4: Gain entry g(0) = 2^23 and g(k) = (g(k-1)*7919352 + 2^22) >> 23, an unsigned Q1.23 value about 0.5 dB below the previous entry. An output is the signed product of the sample and g(index), plus 2^22, arithmetically shifted right by 23 and kept to 24 bits.
- R5: Each accepted sample is scaled with the index held before it arrives. The index then moves by at most one step per accepted sample and does not move without an accepted sample.
- R6: With mute high, each accepted sample raises the index by one, up to MUTE_STEPS+1 (default 241).
- R7: At index MUTE_STEPS+1 (past 240 steps, about -120 dB) both outputs are exactly zero for any input.
- R8: With mute low, each accepted sample lowers the index by one until it reaches 0.
- R9: In normal mode (`bypass` low), `zero_flag` is high after the ZERO_RUN-th (default 1024) consecutive accepted sample with both channels zero. It is low before that. A zero left sample with a nonzero right sample counts as nonzero.
- R10: In bypass mode (`bypass` high), only `s_left` is examined. The run counts consecutive accepted samples whose left value is zero, whatever `s_right` holds.
- R11: Any accepted sample that counts as nonzero clears the run, and `zero_flag` is low right after that acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute | input | 1 | High: fade toward zero; low: fade back to unity |
| bypass | input | 1 | High: zero detection looks at the left lane only |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take an input sample |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream can take the output sample |
| m_left | output | SAMPLE_W | Scaled left sample |
| m_right | output | SAMPLE_W | Scaled right sample |
| zero_flag | output | 1 | Long zero run seen on the input |

## Verification
The assertions assume that `mute` and `bypass` are stable in any cycle where a sample is accepted, and that `m_ready` is driven to a known level in every cycle after reset. The stimulus changes these controls only at falling edges between sample transfers. The stall check also assumes that the output holds are judged only after the start-up hold has ended. The bench stalls the output only after the ramp and zero tests have started, and drives every sample through a handshake task that waits for `s_ready` before it commits.

// File: rtl/mrz_pkg.sv
package mrz_pkg;
  localparam int     GAIN_FRAC = 23;
  localparam int     GAIN_W    = GAIN_FRAC + 1;
  localparam longint STEP_MULT = 64'd7919352;

  // Q1.23 gain after k half-decibel steps, built by repeated rounding.
  function automatic logic [GAIN_W-1:0] gain_at(input int k);
    longint g;
    g = longint'(1) <<< GAIN_FRAC;
    for (int i = 0; i < k; i++)
      g = (g * STEP_MULT + (longint'(1) <<< (GAIN_FRAC - 1))) >>> GAIN_FRAC;
    return g[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/mrz_gain_rom.sv
module mrz_gain_rom #(
  parameter int MUTE_STEPS = 240,
  localparam int IDX_W = $clog2(MUTE_STEPS + 2)
) (
  input  logic [IDX_W-1:0]          idx,
  output logic [mrz_pkg::GAIN_W-1:0] gain
);
  logic [mrz_pkg::GAIN_W-1:0] lut [0:MUTE_STEPS];

  for (genvar k = 0; k <= MUTE_STEPS; k++) begin : g_lut
    localparam logic [mrz_pkg::GAIN_W-1:0] ENTRY = mrz_pkg::gain_at(k);
    assign lut[k] = ENTRY;
  end

  always_comb begin
    if (int'(idx) <= MUTE_STEPS) gain = lut[idx];
    else                         gain = '0;
  end
endmodule

// File: rtl/mrz_scaler.sv
module mrz_scaler #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0]        x,
  input  logic [mrz_pkg::GAIN_W-1:0] gain,
  input  logic                       kill,
  output logic [SAMPLE_W-1:0]        y
);
  localparam int PW = SAMPLE_W + mrz_pkg::GAIN_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (mrz_pkg::GAIN_FRAC - 1);

  logic signed [PW-1:0] xs, gs, prod, rnd;

  always_comb begin
    xs   = PW'($signed(x));
    gs   = PW'($signed({1'b0, gain}));
    prod = xs * gs;
    rnd  = prod + HALF;
    y    = kill ? '0 : rnd[mrz_pkg::GAIN_FRAC +: SAMPLE_W];
  end

  always_comb begin
    if (gain == (mrz_pkg::GAIN_W'(1) << mrz_pkg::GAIN_FRAC) && !kill)
      AST_UNITY_EXACT: assert (y == x);  // R3
  end
endmodule

// File: rtl/mrz_zero_run.sv
module mrz_zero_run #(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 1024,
  localparam int CNT_W = $clog2(ZERO_RUN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                bypass,
  input  logic [SAMPLE_W-1:0] left,
  input  logic [SAMPLE_W-1:0] right,
  output logic                zero_flag
);
  logic             is_zero;
  logic [CNT_W-1:0] run_q, run_d;

  always_comb begin
    is_zero = (left == '0) && (bypass || (right == '0));
    if (!is_zero)                        run_d = '0;
    else if (int'(run_q) < ZERO_RUN)     run_d = run_q + 1'b1;
    else                                 run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      zero_flag <= 1'b0;
    end else if (take) begin
      run_q     <= run_d;
      zero_flag <= (int'(run_d) >= ZERO_RUN);
    end
  end

  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !is_zero |=> !zero_flag);  // R11
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(zero_flag));  // R9
  AST_BYPASS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    take && bypass && left == '0 && zero_flag |=> zero_flag);  // R10
endmodule

// File: rtl/mute_ramp_zdet.sv
module mute_ramp_zdet #(
  parameter int SAMPLE_W    = 24,
  parameter int MUTE_STEPS  = 240,
  parameter int ZERO_RUN    = 1024,
  parameter int INIT_CYCLES = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mute,
  input  logic                bypass,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_left,
  output logic [SAMPLE_W-1:0] m_right,
  output logic                zero_flag
);
  localparam int IDX_W  = $clog2(MUTE_STEPS + 2);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);
  localparam logic [IDX_W-1:0] IDX_SILENT = IDX_W'(MUTE_STEPS + 1);

  logic [INIT_W-1:0]          init_cnt;
  logic                       init_done;
  logic                       accept;
  logic [IDX_W-1:0]           step_idx;
  logic [mrz_pkg::GAIN_W-1:0] gain;
  logic                       silent;
  logic [SAMPLE_W-1:0]        in_lane  [2];
  logic [SAMPLE_W-1:0]        out_lane [2];

  // start-up hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          init_cnt <= '0;
    else if (!init_done) init_cnt <= init_cnt + 1'b1;
  end
  assign init_done = (int'(init_cnt) == INIT_CYCLES);

  assign s_ready = init_done && (!m_valid || m_ready);
  assign accept  = s_valid && s_ready;

  // gain step index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_idx <= '0;
    else if (accept) begin
      if (mute && step_idx != IDX_SILENT)  step_idx <= step_idx + 1'b1;
      else if (!mute && step_idx != '0)    step_idx <= step_idx - 1'b1;
    end
  end

  mrz_gain_rom #(.MUTE_STEPS(MUTE_STEPS)) u_rom (
    .idx  (step_idx),
    .gain (gain)
  );
  assign silent = (step_idx == IDX_SILENT);

  assign in_lane[0] = s_left;
  assign in_lane[1] = s_right;
  for (genvar c = 0; c < 2; c++) begin : g_lane
    mrz_scaler #(.SAMPLE_W(SAMPLE_W)) u_scale (
      .x    (in_lane[c]),
      .gain (gain),
      .kill (silent),
      .y    (out_lane[c])
    );
  end

  // output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_left  <= '0;
      m_right <= '0;
    end else if (accept) begin
      m_valid <= 1'b1;
      m_left  <= out_lane[0];
      m_right <= out_lane[1];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  mrz_zero_run #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_zrun (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (accept),
    .bypass    (bypass),
    .left      (s_left),
    .right     (s_right),
    .zero_flag (zero_flag)
  );

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !s_ready && !m_valid && m_left == '0);  // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_left) && $stable(m_right));  // R2
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(step_idx));  // R5
  AST_IDX_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mute && !silent |=> step_idx == $past(step_idx) + 1'b1);  // R6
  AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && silent |=> m_left == '0 && m_right == '0);  // R7
  AST_IDX_UP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mute && step_idx != '0 |=> step_idx == $past(step_idx) - 1'b1);  // R8
endmodule

// File: tb/mute_ramp_zdet_tb.sv
module mute_ramp_zdet_tb;
  localparam int W     = 24;
  localparam int STEPS = 240;
  localparam int ZRUN  = 1024;
  localparam int INIT  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b0, bypass = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b1;
  logic s_ready, m_valid, zero_flag;
  logic [W-1:0] s_left = '0, s_right = '0, m_left, m_right;

  int checks = 0, fails = 0;
  bit done = 0;
  int idx_m = 0;
  int zrun_m = 0;
  logic [2*W-1:0] expq[$];

  always #2.5 clk = ~clk;

  mute_ramp_zdet #(.SAMPLE_W(W), .MUTE_STEPS(STEPS), .ZERO_RUN(ZRUN),
                   .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .mute(mute), .bypass(bypass),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left), .m_right(m_right),
    .zero_flag(zero_flag));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 gain entry from its recurrence
  function automatic longint ref_gain(input int k);
    longint g = 64'd8388608;
    for (int i = 0; i < k; i++) g = (g * 64'd7919352 + 64'd4194304) >>> 23;
    return g;
  endfunction

  function automatic logic [W-1:0] ref_scale(input logic [W-1:0] x, input int k);
    longint p;
    if (k > STEPS) return '0;
    p = longint'($signed(x)) * ref_gain(k) + 64'sd4194304;
    p = p >>> 23;
    return p[W-1:0];
  endfunction

  // driver: entered and left at a falling edge
  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    expq.push_back({ref_scale(l, idx_m), ref_scale(r, idx_m)});
    if (mute && idx_m < STEPS + 1) idx_m++;
    else if (!mute && idx_m > 0) idx_m--;
    if (l == '0 && (bypass || r == '0)) begin
      if (zrun_m < ZRUN) zrun_m++;
    end else zrun_m = 0;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && !done) begin
      if (expq.size() == 0) check("R2 unexpected output", 1, 0);
      else begin
        logic [2*W-1:0] e;
        e = expq.pop_front();
        check("R4 left", longint'($signed(m_left)), longint'($signed(e[2*W-1:W])));
        check("R4 right", longint'($signed(m_right)), longint'($signed(e[W-1:0])));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset m_valid", m_valid, 0);
    check("R1 reset zero_flag", zero_flag, 0);
    check("R1 reset m_left", m_left, 0);
    rst_n = 1'b1;
    repeat (INIT - 1) @(negedge clk);
    check("R1 hold s_ready", s_ready, 0);
    check("R1 hold m_valid", m_valid, 0);
    @(negedge clk);
    check("R1 ready after hold", s_ready, 1);

    // R3 unity pass-through
    send(24'h7FFFFF, 24'h800000);
    send(24'h123456, 24'hFEDCBA);
    send(24'h000001, 24'hFFFFFF);
    @(negedge clk);
    check("R3 unity idx", idx_m, 0);

    // R2 back-pressure
    m_ready = 1'b0;
    send(24'h0ABCDE, 24'hF00000);
    for (int i = 0; i < 4; i++) begin
      check("R2 stall valid", m_valid, 1);
      check("R2 stall ready low", s_ready, 0);
      check("R2 stall data", m_left, 24'h0ABCDE);
      @(negedge clk);
    end
    m_ready = 1'b1;
    @(negedge clk);

    // R5 R6 R7 mute ramp down to silence
    mute = 1'b1;
    for (int i = 0; i < STEPS + 6; i++)
      send((i % 2) ? 24'h7FFFFF : 24'h800000, 24'h3C0000 - 24'(i));
    check("R7 silent idx model", idx_m, STEPS + 1);
    send(24'h7FFFFF, 24'h800000);
    @(negedge clk);
    check("R7 silent left", m_left, 0);
    check("R7 silent right", m_right, 0);

    // R8 release ramps back
    mute = 1'b0;
    for (int i = 0; i < STEPS + 4; i++) send(24'h400000 + 24'(i), 24'hC00001);
    check("R8 back at unity model", idx_m, 0);
    send(24'h654321, 24'h9ABCDE);
    @(negedge clk);
    check("R8 unity left", m_left, 24'h654321);

    // R9 normal-mode zero run
    for (int i = 0; i < ZRUN - 1; i++) send('0, '0);
    check("R9 flag before run", zero_flag, 0);
    send('0, '0);
    check("R9 flag after run", zero_flag, 1);
    send('0, 24'h000001);
    check("R11 nonzero right drops flag", zero_flag, 0);
    for (int i = 0; i < 10; i++) send('0, '0);
    check("R9 short run low", zero_flag, 0);

    // R10 bypass: right lane ignored
    bypass = 1'b1;
    for (int i = 0; i < ZRUN; i++) send('0, 24'(i + 1));
    check("R10 bypass flag", zero_flag, 1);
    send(24'hFFFFFF, '0);
    check("R11 nonzero left drops flag", zero_flag, 0);
    bypass = 1'b0;

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule